// File: doc/BRIEF.md
# Synchronous Pixel Video Input Receiver

The receiver takes parallel 4:2:2 video from an external source, clocked by the source's pixel clock. A 16-bit input carries luma in the upper byte and an interleaved Cb/Cr stream in the lower byte. Six control inputs come with the data: a line-start strobe, a field-start strobe, an active-region flag, a per-pixel valid qualifier, a chroma-phase flag and a field-parity level. Line and field starts are the falling edges of active-low pulses of variable width. Only samples taken inside the active region that are also marked valid are kept.

Kept samples are paired by chroma phase. A Cb-tagged sample followed by a Cr-tagged sample gives one 32-bit pixel-pair word `{Y0, Cb, Y1, Cr}`. Each word goes out on a valid/ready stream with start-of-line, start-of-field and field-parity tags. Capture never stalls. If a new word is ready while the previous one is still waiting, the new word is dropped and a sticky overflow flag is raised. A Cr sample that has no Cb half waiting is dropped and counted.

Top module: `pix_video_rx`

## Requirements
- R1: After a synchronous active-low reset, `o_valid`, `o_ovf` and `o_phase_errs` are all 0.
- R2: No sample is accepted and no word is produced until the first falling edge of `i_line_n` after reset. A falling edge is a 1 on the previous rising clock edge and a 0 on the current one.
- R3: A sample is accepted only when `i_act` and `i_dval` are both high. Other samples leave the pairing state and the outputs unchanged.
- R4: The upper byte of `i_data` is luma and the lower byte is chroma. An accepted sample with `i_cbph`=1 is a Cb half. The next accepted sample with `i_cbph`=0 completes the word `o_data` = {Y0, Cb, Y1, Cr}, with Y0 in bits 31:24 and Cr in bits 7:0. `o_valid` is high after the clock edge that captured the Cr sample.
- R5: An accepted Cr sample that has no Cb half waiting produces no word. It adds 1 to `o_phase_errs`, which saturates.
- R6: `o_sol` is 1 on a word whose Cb half was the first accepted sample after a falling edge of `i_line_n`, and 0 on every other word.
- R7: `o_sof` is 1 on a word whose Cb half was the first accepted sample after a falling edge of `i_field_n`, and 0 on every other word.
- R8: `o_parity` carries the value `i_fld` last had on a clock edge where `i_field_n` was low (1 = even field). Changes of `i_fld` while `i_field_n` is high have no effect.
- R9: When a new word completes while `o_valid`=1 and `o_rdy`=0, the new word is dropped and `o_ovf` is set. `o_ovf` stays set until it is cleared.
- R10: `i_ovf_clr` high on a clock edge clears `o_ovf`. The clear wins over a new overflow on the same edge.
- R11: A falling edge of `i_line_n` discards a waiting Cb half.
- R12: While `o_valid`=1 and `o_rdy`=0, `o_valid` and `o_data` hold. Once the word is taken and no new word completes, `o_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_data | input | 16 | Luma byte [15:8], chroma byte [7:0] |
| i_line_n | input | 1 | Active-low line pulse, line starts at falling edge |
| i_field_n | input | 1 | Active-low field pulse, field starts at falling edge |
| i_act | input | 1 | Active (non-blanking) region |
| i_dval | input | 1 | Per-pixel valid qualifier |
| i_cbph | input | 1 | Chroma lane holds Cb when high, Cr when low |
| i_fld | input | 1 | Field parity, 1 = even field |
| i_ovf_clr | input | 1 | Clears the overflow flag |
| o_rdy | input | 1 | Downstream ready |
| o_valid | output | 1 | Word valid |
| o_data | output | 32 | Pixel pair {Y0, Cb, Y1, Cr} |
| o_sol | output | 1 | Word begins a line |
| o_sof | output | 1 | Word begins a field |
| o_parity | output | 1 | Field parity of the word |
| o_ovf | output | 1 | Sticky overflow flag |
| o_phase_errs | output | 8 | Saturating count of orphan Cr samples |

## Verification
Errors in the pairing state show up on the next Cr sample. A Cb half that is lost or left over appears either as a missing word or as a phase-error count one clock edge later, and the bench checks both after every Cr sample. A wrong tag register or parity latch corrupts the tags of the first word of a line or field, and these tags can be read as soon as that word is valid. A broken hold path under backpressure changes `o_data` on the very next edge, before the word is taken.

// File: rtl/pix_video_rx.sv
module pix_video_rx #(
  parameter int DW    = 8,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] i_data,
  input  logic            i_line_n,
  input  logic            i_field_n,
  input  logic            i_act,
  input  logic            i_dval,
  input  logic            i_cbph,
  input  logic            i_fld,
  input  logic            i_ovf_clr,
  input  logic            o_rdy,
  output logic            o_valid,
  output logic [4*DW-1:0] o_data,
  output logic            o_sol,
  output logic            o_sof,
  output logic            o_parity,
  output logic            o_ovf,
  output logic [CNT_W-1:0] o_phase_errs
);

  logic          line_q, field_q, line_seen;
  logic          pend_sol, pend_sof, par_q, have_cb;
  logic [DW-1:0] y0_q, cb_q;
  logic          sol_q, sof_q, wpar_q;

  wire [DW-1:0] y_in = i_data[2*DW-1:DW];
  wire [DW-1:0] c_in = i_data[DW-1:0];

  wire line_fall  = line_q & ~i_line_n;
  wire field_fall = field_q & ~i_field_n;
  wire accept     = line_seen & i_act & i_dval;
  wire cb_acc     = accept & i_cbph;
  wire cr_acc     = accept & ~i_cbph;
  wire half_ok    = have_cb & ~line_fall;
  wire pair_done  = cr_acc & half_ok;
  wire orphan     = cr_acc & ~half_ok;
  wire blocked    = o_valid & ~o_rdy;
  wire sat        = &o_phase_errs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0; field_q <= 1'b0; line_seen <= 1'b0;
      pend_sol <= 1'b0; pend_sof <= 1'b0; par_q <= 1'b0;
      have_cb <= 1'b0; y0_q <= '0; cb_q <= '0;
      sol_q <= 1'b0; sof_q <= 1'b0; wpar_q <= 1'b0;
      o_valid <= 1'b0; o_data <= '0; o_sol <= 1'b0; o_sof <= 1'b0;
      o_parity <= 1'b0; o_ovf <= 1'b0; o_phase_errs <= '0;
    end else begin
      line_q  <= i_line_n;
      field_q <= i_field_n;
      if (line_fall) line_seen <= 1'b1;
      if (!i_field_n) par_q <= i_fld;

      if (accept)          pend_sol <= 1'b0;
      else if (line_fall)  pend_sol <= 1'b1;
      if (accept)          pend_sof <= 1'b0;
      else if (field_fall) pend_sof <= 1'b1;

      if (cb_acc) begin
        have_cb <= 1'b1;
        y0_q    <= y_in;
        cb_q    <= c_in;
        sol_q   <= pend_sol | line_fall;
        sof_q   <= pend_sof | field_fall;
        wpar_q  <= i_field_n ? par_q : i_fld;
      end else if (cr_acc || line_fall) begin
        have_cb <= 1'b0;
      end

      if (orphan && !sat) o_phase_errs <= o_phase_errs + 1'b1;

      if (pair_done && !blocked) begin
        o_valid  <= 1'b1;
        o_data   <= {y0_q, cb_q, y_in, c_in};
        o_sol    <= sol_q;
        o_sof    <= sof_q;
        o_parity <= wpar_q;
      end else if (o_rdy) begin
        o_valid <= 1'b0;
      end

      if (i_ovf_clr)                 o_ovf <= 1'b0;
      else if (pair_done && blocked) o_ovf <= 1'b1;
    end
  end

  p_no_word_before_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_seen |-> !o_valid);
  p_word_needs_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> $past(i_act && i_dval));
  p_errs_monotonic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> o_phase_errs >= $past(o_phase_errs));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_ovf && !i_ovf_clr |=> o_ovf);
  p_ovf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    i_ovf_clr |=> !o_ovf);
  p_hold_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_rdy |=> o_valid && $stable(o_data));

endmodule

// File: tb/pix_video_rx_test.sv
module pix_video_rx_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] i_data = 0;
  logic i_line_n = 1, i_field_n = 1, i_act = 0, i_dval = 0, i_cbph = 0, i_fld = 0;
  logic i_ovf_clr = 0, o_rdy = 1;
  logic o_valid, o_sol, o_sof, o_parity, o_ovf;
  logic [31:0] o_data;
  logic [7:0] o_phase_errs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pix_video_rx uut (.clk, .rst_n, .i_data, .i_line_n, .i_field_n, .i_act, .i_dval,
    .i_cbph, .i_fld, .i_ovf_clr, .o_rdy, .o_valid, .o_data, .o_sol, .o_sof,
    .o_parity, .o_ovf, .o_phase_errs);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [7:0] y, logic [7:0] c, logic cb, logic a, logic d);
    i_data = {y, c}; i_cbph = cb; i_act = a; i_dval = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic line_pulse(int w);
    i_line_n = 0; idle(w); i_line_n = 1; idle(1);
  endtask

  task automatic t_reset;
    chk("R1 valid", o_valid, 0);
    chk("R1 ovf", o_ovf, 0);
    chk("R1 errs", o_phase_errs, 0);
  endtask

  task automatic t_no_line;
    step(8'h01, 8'h02, 1, 1, 1);
    step(8'h03, 8'h04, 0, 1, 1);
    chk("R2 no word before line start", o_valid, 0);
    chk("R2 no orphan counted", o_phase_errs, 0);
  endtask

  task automatic t_line_words;
    line_pulse(3);
    step(8'h11, 8'hA1, 1, 1, 1);
    step(8'h22, 8'hB2, 0, 1, 1);
    chk("R4 valid", o_valid, 1);
    chk("R4 data", o_data, 32'h11A122B2);
    chk("R6 sol first", o_sol, 1);
    step(8'h33, 8'hC3, 1, 1, 1);
    chk("R12 valid drops", o_valid, 0);
    step(8'h44, 8'hD4, 0, 1, 1);
    chk("R4 data2", o_data, 32'h33C344D4);
    chk("R6 sol second", o_sol, 0);
  endtask

  task automatic t_gating;
    step(8'h55, 8'hE5, 1, 1, 1);
    step(8'h99, 8'h99, 0, 1, 0);
    step(8'h98, 8'h98, 0, 0, 1);
    chk("R3 gated no word", o_valid, 0);
    step(8'h66, 8'hF6, 0, 1, 1);
    chk("R3 data", o_data, 32'h55E566F6);
    chk("R3 errs", o_phase_errs, 0);
  endtask

  task automatic t_phase;
    step(8'h77, 8'h17, 0, 1, 1);
    chk("R5 orphan no word", o_valid, 0);
    chk("R5 count", o_phase_errs, 1);
  endtask

  task automatic t_field;
    i_fld = 1; i_field_n = 0; idle(2); i_field_n = 1; idle(1);
    i_fld = 0;
    line_pulse(1);
    step(8'h12, 8'h34, 1, 1, 1);
    step(8'h56, 8'h78, 0, 1, 1);
    chk("R7 sof", o_sof, 1);
    chk("R8 parity", o_parity, 1);
    chk("R6 sol", o_sol, 1);
    step(8'h9A, 8'hBC, 1, 1, 1);
    step(8'hDE, 8'hF0, 0, 1, 1);
    chk("R7 sof second", o_sof, 0);
    chk("R8 parity held", o_parity, 1);
  endtask

  task automatic t_hdiscard;
    step(8'h21, 8'h43, 1, 1, 1);
    line_pulse(2);
    step(8'h65, 8'h87, 0, 1, 1);
    chk("R11 no word", o_valid, 0);
    chk("R11 orphan", o_phase_errs, 2);
  endtask

  task automatic t_ovf;
    o_rdy = 0;
    step(8'hA0, 8'hA1, 1, 1, 1);
    step(8'hA2, 8'hA3, 0, 1, 1);
    chk("R12 valid", o_valid, 1);
    step(8'hB0, 8'hB1, 1, 1, 1);
    step(8'hB2, 8'hB3, 0, 1, 1);
    chk("R9 ovf", o_ovf, 1);
    chk("R12 data held", o_data, 32'hA0A1A2A3);
    chk("R12 still valid", o_valid, 1);
    o_rdy = 1; idle(1);
    chk("R12 taken", o_valid, 0);
    chk("R9 sticky", o_ovf, 1);
    i_ovf_clr = 1; idle(1); i_ovf_clr = 0;
    chk("R10 cleared", o_ovf, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; idle(1);
    t_reset; t_no_line; t_line_words; t_gating; t_phase;
    t_field; t_hdiscard; t_ovf;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule